// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block holds the programming state of one DMA channel as four 32-bit words on a simple word-wide register bus. Word 0 is the control/status register (CSR). It carries a fixed version stamp, a set of bits that software cannot change, an interrupt pending flag and an interrupt enable flag, a FIFO drain flag, a direction flag and a self-clearing reset command. Words 1 to 3 hold the transfer address and two further channel parameters, and store whatever is written to them.

The attached peripheral drives a level-sensitive interrupt line into the block. The block latches that line as the pending flag and presents an interrupt output gated by the enable flag. Writing the reset command sends a one-cycle reset pulse to the peripheral. Reads come from a combinational multiplexer and have no side effects. Every update takes place on one rising clock edge. Reset is asynchronous and active-low.

Top module: `dmac_regbank`

## Requirements
- R1: After reset, word 0 reads 0xA000_0000, words 1 to 3 read 0, and the interrupt output and the peripheral reset output are low.
- R2: The word index comes from address bits [3:2]. Address bits above bit 3 are ignored, so a window placed at byte offset 0x10, or at any other multiple of 16, decodes the same as one at offset 0.
- R3: The read-only mask is 0xFE00_0007, covering bits 31..25 and bits 2..0. A CSR write keeps the old values of the bits under this mask and takes every other bit from the written data. Bits 31 and 29 (version 0xA000_0000) are always set.
- R4: A CSR write with bit 7 clear and bit 6 (drain) set stores bit 6 as 0. A CSR write of exactly zero stores bit 6 as 1.
- R5: A CSR write with bit 7 set drives the peripheral reset output high for the single cycle after the write edge. Bit 7 always reads back as 0.
- R6: A write to word 1 sets CSR bit 26 (address loaded). Writes to words 1 to 3 store the data unchanged.
- R7: A rising interrupt input level sets CSR bit 0 (pending). A falling level clears it.
- R8: The interrupt output equals pending AND CSR bit 4 (enable). It is updated on the same edge as the CSR write or level change that causes it.
- R9: Read data is combinational from the stored state. A cycle without a write leaves CSR bits 31..1 unchanged.
- R10: When a CSR write and an interrupt level change fall on the same edge, the write is applied first and the level change second. The level change acts on the newly written enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| periph_irq_lvl | input | 1 | Interrupt level from the attached peripheral |
| irq_out | output | 1 | Gated interrupt output |
| periph_rst | output | 1 | One-cycle reset pulse to the peripheral |

## Verification
A write presented before edge k shows in the read data, the interrupt output and the pulse output right after edge k. A level change follows the same rule, so every result is due one edge after its stimulus and never later. The bench drives inputs on falling edges and updates a behavioural model on each rising edge. It compares all three outputs one nanosecond after that rising edge. Directed reads are made on falling edges, one full edge after the write they follow, and the pulse is checked in that cycle and again in the next one to confirm it lasts one cycle only.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int unsigned DW = 32;
  localparam logic [DW-1:0] CSR_VERSION = 32'hA000_0000;
  localparam logic [DW-1:0] CSR_RO_MASK = 32'hFE00_0007;
  localparam int unsigned BIT_PEND   = 0;
  localparam int unsigned BIT_IEN    = 4;
  localparam int unsigned BIT_DRAIN  = 6;
  localparam int unsigned BIT_RSTCMD = 7;
  localparam int unsigned BIT_TOMEM  = 8;
  localparam int unsigned BIT_LOADED = 26;
endpackage

// File: rtl/dmac_irq_gate.sv
module dmac_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  input  logic wr_csr,
  input  logic wr_ien,
  input  logic ien_old,
  output logic pend_q,
  output logic irq_q
);
  logic lvl_q;
  logic lvl_rise, lvl_fall, ien_new;
  logic pend_d, irq_d;

  always_comb begin
    lvl_rise = level_in & ~lvl_q;
    lvl_fall = ~level_in & lvl_q;
    ien_new  = wr_csr ? wr_ien : ien_old;
    irq_d    = irq_q;
    pend_d   = pend_q;
    // bus write first
    if (wr_csr) begin
      if (wr_ien && pend_q)
        irq_d = 1'b1;
      else if (!wr_ien && (pend_q || ien_old))
        irq_d = 1'b0;
    end
    // then the level event, seen against the new enable
    if (lvl_rise) begin
      pend_d = 1'b1;
      if (ien_new) irq_d = 1'b1;
    end else if (lvl_fall && pend_q) begin
      pend_d = 1'b0;
      if (ien_new) irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      lvl_q  <= level_in;
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  AST_PEND_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (level_in && !lvl_q) |=> pend_q); // R7
  AST_PEND_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_in && lvl_q) |=> !pend_q); // R7
endmodule

// File: rtl/dmac_csr.sv
module dmac_csr
  import dmac_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_csr,
  input  logic [DW-1:0] wdata,
  input  logic          set_loaded,
  input  logic          pend,
  output logic [DW-1:0] csr,
  output logic          ien,
  output logic          rst_pulse
);
  logic [DW-1:0] body_q, body_d, wval;
  logic          body_en, pulse_d;

  always_comb begin
    wval    = wdata;
    pulse_d = 1'b0;
    body_d  = body_q;
    if (wr_csr) begin
      if (wdata[BIT_RSTCMD])
        pulse_d = 1'b1;
      else if (wdata[BIT_DRAIN])
        wval[BIT_DRAIN] = 1'b0;
      else if (wdata == '0)
        wval[BIT_DRAIN] = 1'b1;
      wval[BIT_RSTCMD] = 1'b0;
      body_d = (body_q & CSR_RO_MASK) | (wval & ~CSR_RO_MASK) | CSR_VERSION;
    end
    if (set_loaded)
      body_d[BIT_LOADED] = 1'b1;
  end

  assign body_en = wr_csr | set_loaded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      body_q    <= CSR_VERSION;
      rst_pulse <= 1'b0;
    end else begin
      if (body_en) body_q <= body_d;
      rst_pulse <= pulse_d;
    end
  end

  assign csr = {body_q[DW-1:1], pend};
  assign ien = body_q[BIT_IEN];

  AST_VERSION_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (csr[31:27] == 5'b10100) && !csr[25]); // R3
  AST_DRAIN_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_csr && wdata == '0) |=> csr[BIT_DRAIN]); // R4
  AST_PULSE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_csr && wdata[BIT_RSTCMD]) |=> rst_pulse); // R5
  AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> $past(wr_csr && wdata[BIT_RSTCMD])); // R5
endmodule

// File: rtl/dmac_gpregs.sv
module dmac_gpregs
  import dmac_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       idx,
  input  logic [DW-1:0]          wdata,
  output logic [NUM_REGS*DW-1:0] regs_flat
);
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_slot
    if (gi == 0) begin : g_csr_hole
      assign regs_flat[gi*DW +: DW] = '0;
    end else begin : g_reg
      logic          en;
      logic [DW-1:0] q;
      assign en = we && (idx == IDX_W'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (en) q <= wdata;
      end
      assign regs_flat[gi*DW +: DW] = q;
    end
  end
endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank
  import dmac_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              periph_irq_lvl,
  output logic              irq_out,
  output logic              periph_rst
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);
  localparam int unsigned OFS_W = IDX_W + 2;

  logic [IDX_W-1:0]       idx;
  logic                   wr_csr, set_loaded, pend, ien;
  logic [DW-1:0]          csr;
  logic [NUM_REGS*DW-1:0] gp_flat;

  assign idx        = reg_addr[OFS_W-1:2];
  assign wr_csr     = reg_we && (idx == '0);
  assign set_loaded = reg_we && (idx == IDX_W'(1));

  dmac_csr u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_csr    (wr_csr),
    .wdata     (reg_wdata),
    .set_loaded(set_loaded),
    .pend      (pend),
    .csr       (csr),
    .ien       (ien),
    .rst_pulse (periph_rst)
  );

  dmac_irq_gate u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_in(periph_irq_lvl),
    .wr_csr  (wr_csr),
    .wr_ien  (reg_wdata[BIT_IEN]),
    .ien_old (ien),
    .pend_q  (pend),
    .irq_q   (irq_out)
  );

  dmac_gpregs #(.NUM_REGS(NUM_REGS)) u_gp (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .idx      (idx),
    .wdata    (reg_wdata),
    .regs_flat(gp_flat)
  );

  always_comb begin
    if (idx == '0) reg_rdata = csr;
    else           reg_rdata = gp_flat[idx*DW +: DW];
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (pend && ien)); // R8
  AST_LOADED_ON_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    set_loaded |=> csr[BIT_LOADED]); // R6
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(csr[31:1])); // R9
endmodule

// File: tb/sim_dmac_regbank.sv
`timescale 1ns/1ps
module sim_dmac_regbank;
  localparam logic [31:0] VER = 32'hA000_0000;
  localparam logic [31:0] RO  = 32'hFE00_0007;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        periph_irq_lvl;
  logic        irq_out;
  logic        periph_rst;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  dmac_regbank #(.ADDR_W(12), .NUM_REGS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .periph_irq_lvl(periph_irq_lvl), .irq_out(irq_out), .periph_rst(periph_rst)
  );

  // behavioural reference model
  logic [31:0] m [4];
  logic        m_irq, m_pulse, m_lvl;
  logic [31:0] v;
  logic        en_old;
  int          wi;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m[0] = VER; m[1] = 0; m[2] = 0; m[3] = 0;
      m_irq = 0; m_pulse = 0; m_lvl = 0;
    end else begin
      m_pulse = 0;
      if (reg_we) begin
        wi = int'(reg_addr[3:2]);
        if (wi == 0) begin
          v = reg_wdata;
          en_old = m[0][4];
          if (v[7]) m_pulse = 1;
          else if (v[6]) v[6] = 0;
          else if (v == 0) v[6] = 1;
          v[7] = 0;
          m[0] = (m[0] & RO) | (v & ~RO) | VER;
          if (v[4] && m[0][0]) m_irq = 1;
          else if (!v[4] && (m[0][0] || en_old)) m_irq = 0;
        end else begin
          m[wi] = reg_wdata;
          if (wi == 1) m[0][26] = 1;
        end
      end
      if (periph_irq_lvl && !m_lvl) begin
        m[0][0] = 1;
        if (m[0][4]) m_irq = 1;
      end else if (!periph_irq_lvl && m_lvl && m[0][0]) begin
        m[0][0] = 0;
        if (m[0][4]) m_irq = 0;
      end
      m_lvl = periph_irq_lvl;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    chk("R9 rdata vs model", reg_rdata, m[reg_addr[3:2]]);
    chk("R8 irq_out vs model", {31'd0, irq_out}, {31'd0, m_irq});
    chk("R5 periph_rst vs model", {31'd0, periph_rst}, {31'd0, m_pulse});
  end

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic set_lvl(input logic l);
    @(negedge clk);
    periph_irq_lvl = l;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; periph_irq_lvl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_chk("R1 csr reset", 12'h000, VER);
    rd_chk("R1 word1 reset", 12'h004, 0);
    rd_chk("R1 word2 reset", 12'h008, 0);
    rd_chk("R1 word3 reset", 12'h00C, 0);
    chk("R1 irq reset", {31'd0, irq_out}, 0);
    chk("R1 pulse reset", {31'd0, periph_rst}, 0);

    // R6 address write and loaded flag
    bus_write(12'h004, 32'h1234_5678);
    rd_chk("R6 word1 value", 12'h004, 32'h1234_5678);
    rd_chk("R6 loaded bit", 12'h000, 32'hA400_0000);

    // R2 aliasing above bit 3
    bus_write(12'h018, 32'hCAFE_F00D);
    rd_chk("R2 alias word2", 12'h008, 32'hCAFE_F00D);
    rd_chk("R2 high addr word1", 12'hFF4, 32'h1234_5678);
    bus_write(12'h01C, 32'h0BAD_BEEF);
    rd_chk("R6 word3 value", 12'h00C, 32'h0BAD_BEEF);

    // R5 reset command
    bus_write(12'h000, 32'hFFFF_FFFF);
    chk("R5 pulse high", {31'd0, periph_rst}, 1);
    #1 chk("R5 csr after all-ones", reg_rdata, 32'hA5FF_FF78);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'd0, periph_rst}, 0);

    // R4 drain rules
    bus_write(12'h000, 32'h0000_0050);
    rd_chk("R4 drain stored zero", 12'h000, 32'hA400_0010);
    bus_write(12'h000, 32'h0000_0000);
    rd_chk("R4 zero sets drain", 12'h000, 32'hA400_0040);

    // R7 / R8 level handling
    bus_write(12'h000, 32'h0000_0010);
    set_lvl(1);
    rd_chk("R7 pending set", 12'h000, 32'hA400_0011);
    chk("R8 irq raised", {31'd0, irq_out}, 1);
    set_lvl(0);
    rd_chk("R7 pending cleared", 12'h000, 32'hA400_0010);
    chk("R8 irq lowered", {31'd0, irq_out}, 0);

    bus_write(12'h000, 32'h0000_0000);
    set_lvl(1);
    rd_chk("R7 pending masked", 12'h000, 32'hA400_0041);
    chk("R8 irq masked", {31'd0, irq_out}, 0);
    bus_write(12'h000, 32'h0000_0010);
    chk("R8 enable raises irq", {31'd0, irq_out}, 1);
    bus_write(12'h000, 32'h0000_0100);
    chk("R8 disable lowers irq", {31'd0, irq_out}, 0);
    rd_chk("R3 pending kept by write", 12'h000, 32'hA400_0101);

    // R10 same-edge write and falling level
    @(negedge clk);
    reg_we = 1; reg_addr = 0; reg_wdata = 32'h0000_0010; periph_irq_lvl = 0;
    @(negedge clk);
    reg_we = 0;
    chk("R10 irq after combined", {31'd0, irq_out}, 0);
    rd_chk("R10 csr after combined", 12'h000, 32'hA400_0010);

    // R3 read-only bits
    bus_write(12'h000, 32'hFE00_0017);
    rd_chk("R3 ro bits kept", 12'h000, 32'hA400_0010);

    // R1 again after mid-run reset
    do_reset();
    rd_chk("R1 csr after rerun reset", 12'h000, VER);
    rd_chk("R1 word1 after rerun reset", 12'h004, 0);

    // mixed traffic against the model
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      reg_we   = ($urandom_range(0, 2) == 0);
      reg_addr = 12'($urandom());
      case ($urandom_range(0, 5))
        0:       reg_wdata = 32'h0;
        1:       reg_wdata = 32'h10;
        2:       reg_wdata = 32'h50;
        default: reg_wdata = $urandom();
      endcase
      if ($urandom_range(0, 7) == 0) periph_irq_lvl = ~periph_irq_lvl;
    end
    @(negedge clk);
    reg_we = 0;
    repeat (2) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule